// File: doc/BRIEF.md
# Spindle Spin Detection and Spin-Up Timer

This block runs ahead of every disk transfer. When a new operation is started, it first decides whether the requested drive's spindle is already turning. To do this it samples the controller's read data latch at a fixed spacing. If any two consecutive samples differ, the disk is taken to be spinning. If the requested drive differs from the drive used last time, the result is forced to "not spinning", because any activity seen belongs to the other drive.

After detection the block always switches the motor on. A drive that was standing still gets a fixed settle interval before stepping is allowed, so that the head does not move during the motor's inrush current. A motor-on-time counter is preloaded when the motor comes on. It advances once per time unit, and each unit is a parameterised number of microsecond ticks. The counter keeps running through the settle interval and through the seek, so the seek's duration is credited toward the spin-up time. Data access is released once the counter wraps to zero. For a drive that was already spinning, access is released as soon as the seek is reported complete. A stop input ends the operation, switches the motor off and returns the block to idle.

All pins are plain control and status levels or pulses. No data stream passes through the block, so no handshake is needed.

Top module: `spindle_spinup`

## Requirements
- R1: After `op_start` in idle, the latch is sampled once as a reference, then compared up to `NUM_CMP` (8) more times. Samples are `SAMPLE_GAP` (14) cycles apart, and `latch_strobe` is high for exactly the one cycle of each sample. Comparison is always against the previous sample. A mismatch ends detection early with activity; 8 matching compares end it without activity. All samples are taken with the motor off.
- R2: Activity counts as "spinning" only if `drive_sel` captured at `op_start` (0 = first drive, 1 = second drive) equals the drive of the previous operation. After reset the previous drive is 0.
- R3: The motor turns on when detection ends, whatever the result. `spin_found` is high while the motor is on if the drive was judged spinning.
- R4: When not spinning, `seek_ok` rises exactly `SETTLE_UNITS` (7) units after `motor_on` rises.
- R5: When spinning, `seek_ok` rises in the same cycle as `motor_on`. `seek_ok` stays high until `seek_done` or stop.
- R6: At motor on, a `CNT_W`-bit counter loads `CNT_PRELOAD` and adds 1 per unit until it reaches zero. A unit is `UNIT_TICKS` `us_tick` pulses counted from motor on. For a drive that was not spinning, `ready` rises one cycle after the counter reaches zero.
- R7: The counter runs during settle and seek. When a not-spinning seek completes after the counter has reached zero, `ready` rises in the cycle after the cycle in which `seek_done` is high.
- R8: When spinning, `ready` rises in the cycle after the cycle in which `seek_done` is high, without waiting for the counter. `ready` stays high until stop, and a further `op_start` has no effect on it.
- R9: `stop` switches the motor off and returns to idle on the next edge. This takes priority over a `seek_done` in the same cycle; in that case `ready` never rises.
- R10: After reset, `motor_on`, `seek_ok`, `ready`, `spin_found` and `latch_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Pulse: begin an operation (idle only) |
| drive_sel | input | 1 | Requested drive, 0 or 1, captured at op_start |
| stop | input | 1 | End operation: motor off, back to idle |
| latch_data | input | DATA_W | Current read data latch value |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| seek_done | input | 1 | Pulse: head positioning finished |
| latch_strobe | output | 1 | High in each cycle the latch is sampled |
| motor_on | output | 1 | Spindle motor enable |
| spin_found | output | 1 | Drive was judged already spinning |
| seek_ok | output | 1 | Head stepping may proceed |
| ready | output | 1 | Data access allowed |

## Verification
Two pairs of events can land in the same cycle.

The first pair is the end of a seek and the expiry of the spin-up counter. The bench provokes this with a short seek and with a seek long enough to outlast the counter. It predicts `ready` as the later of the `seek_done` cycle and one cycle past expiry. A scoreboard compares that prediction against the measured rise.

The second pair is `stop` and `seek_done`, driven high together in the seek phase. Here the stop must win: the motor drops on the next edge and `ready` never appears.

// File: rtl/spin_pkg.sv
package spin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DETECT,
    ST_SETTLE,
    ST_SEEK,
    ST_SPINUP,
    ST_READY
  } spin_state_e;
endpackage

// File: rtl/spin_detect.sv
module spin_detect #(
  parameter int DATA_W = 8,
  parameter int SAMPLE_GAP = 14,
  parameter int NUM_CMP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] latch_data,
  output logic              strobe,
  output logic              done,
  output logic              active
);
  localparam int GAP_W = $clog2(SAMPLE_GAP + 1);
  localparam int CMP_W = $clog2(NUM_CMP + 1);

  logic              busy;
  logic              have_ref;
  logic [GAP_W-1:0]  gap_cnt;
  logic [CMP_W-1:0]  cmp_cnt;
  logic [DATA_W-1:0] ref_q;

  assign strobe = busy && (gap_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      have_ref <= 1'b0;
      gap_cnt  <= '0;
      cmp_cnt  <= '0;
      ref_q    <= '0;
      done     <= 1'b0;
      active   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy     <= 1'b1;
        have_ref <= 1'b0;
        gap_cnt  <= '0;
        cmp_cnt  <= '0;
      end else if (busy) begin
        gap_cnt <= (gap_cnt == GAP_W'(SAMPLE_GAP - 1)) ? '0 : gap_cnt + 1'b1;
        if (strobe) begin
          ref_q <= latch_data;
          if (!have_ref) begin
            have_ref <= 1'b1;
          end else if (latch_data != ref_q) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            active <= 1'b1;
          end else if (cmp_cnt == CMP_W'(NUM_CMP - 1)) begin
            busy   <= 1'b0;
            done   <= 1'b1;
            active <= 1'b0;
          end else begin
            cmp_cnt <= cmp_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spin_timebase.sv
module spin_timebase #(
  parameter int UNIT_TICKS = 100,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_PRELOAD = 16'hD8F0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic us_tick,
  output logic unit,
  output logic expired
);
  localparam int PRE_W = $clog2(UNIT_TICKS + 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] on_time;

  assign unit    = run && us_tick && (pre_cnt == PRE_W'(UNIT_TICKS - 1));
  assign expired = (on_time == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      on_time <= CNT_PRELOAD;
    end else if (load) begin
      pre_cnt <= '0;
      on_time <= CNT_PRELOAD;
    end else if (run && us_tick) begin
      pre_cnt <= unit ? '0 : pre_cnt + 1'b1;
      if (unit && !expired) on_time <= on_time + 1'b1;
    end
  end
endmodule

// File: rtl/spindle_spinup.sv
module spindle_spinup
  import spin_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SAMPLE_GAP = 14,
  parameter int NUM_CMP = 8,
  parameter int UNIT_TICKS = 100,
  parameter int SETTLE_UNITS = 7,
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_PRELOAD = 16'hD8F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              drive_sel,
  input  logic              stop,
  input  logic [DATA_W-1:0] latch_data,
  input  logic              us_tick,
  input  logic              seek_done,
  output logic              latch_strobe,
  output logic              motor_on,
  output logic              spin_found,
  output logic              seek_ok,
  output logic              ready
);
  localparam int SET_W = $clog2(SETTLE_UNITS + 1);

  spin_state_e      state;
  logic             drv_q, last_drv, spun;
  logic [SET_W-1:0] set_cnt;
  logic             det_go, det_done, det_active;
  logic             tb_load, unit, expired, spun_n;

  assign det_go   = (state == ST_IDLE) && op_start;
  assign tb_load  = (state == ST_DETECT) && det_done && !stop;
  assign spun_n   = det_active && (drv_q == last_drv);
  assign motor_on = (state == ST_SETTLE) || (state == ST_SEEK) ||
                    (state == ST_SPINUP) || (state == ST_READY);
  assign seek_ok  = (state == ST_SEEK);
  assign ready    = (state == ST_READY);
  assign spin_found = motor_on && spun;

  spin_detect #(
    .DATA_W(DATA_W), .SAMPLE_GAP(SAMPLE_GAP), .NUM_CMP(NUM_CMP)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .go(det_go), .latch_data(latch_data),
    .strobe(latch_strobe), .done(det_done), .active(det_active)
  );

  spin_timebase #(
    .UNIT_TICKS(UNIT_TICKS), .CNT_W(CNT_W), .CNT_PRELOAD(CNT_PRELOAD)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .load(tb_load), .run(motor_on),
    .us_tick(us_tick), .unit(unit), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      drv_q    <= 1'b0;
      last_drv <= 1'b0;
      spun     <= 1'b0;
      set_cnt  <= '0;
    end else if (stop && state != ST_IDLE) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (op_start) begin
          drv_q <= drive_sel;
          state <= ST_DETECT;
        end
        ST_DETECT: if (det_done) begin
          spun     <= spun_n;
          last_drv <= drv_q;
          set_cnt  <= '0;
          state    <= spun_n ? ST_SEEK : ST_SETTLE;
        end
        ST_SETTLE: if (unit) begin
          if (set_cnt == SET_W'(SETTLE_UNITS - 1)) state <= ST_SEEK;
          else set_cnt <= set_cnt + 1'b1;
        end
        ST_SEEK: if (seek_done) state <= (spun || expired) ? ST_READY : ST_SPINUP;
        ST_SPINUP: if (expired) state <= ST_READY;
        ST_READY: state <= ST_READY;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spindle_spinup_chk.sv
module spindle_spinup_chk (
  input logic clk,
  input logic rst_n,
  input logic stop,
  input logic latch_strobe,
  input logic motor_on,
  input logic spin_found,
  input logic seek_ok,
  input logic ready
);
  AST_STROBE_MOTOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    latch_strobe |-> !motor_on); // R1
  AST_FOUND_NEEDS_MOTOR: assert property (@(posedge clk) disable iff (!rst_n)
    spin_found |-> motor_on); // R3
  AST_SEEK_NEEDS_MOTOR: assert property (@(posedge clk) disable iff (!rst_n)
    seek_ok |-> motor_on); // R5
  AST_SEEK_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seek_ok && ready)); // R6
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !stop |=> ready); // R8
  AST_STOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !motor_on && !ready && !seek_ok); // R9
endmodule

bind spindle_spinup spindle_spinup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .latch_strobe(latch_strobe),
  .motor_on(motor_on), .spin_found(spin_found), .seek_ok(seek_ok), .ready(ready)
);

// File: tb/sim_spindle_spinup.sv
module sim_spindle_spinup;
  localparam int U = 4;
  localparam int PRE_UNITS = 32;
  localparam int SET_UNITS = 7;
  localparam int NCMP = 8;

  typedef struct { bit spun; int strobes; } exp_t;
  exp_t q[$];

  logic clk = 0, rst_n = 0, op_start = 0, drive_sel = 0, stop = 0;
  logic seek_done = 0, us_tick = 1;
  logic [7:0] latch_data = 8'h5A;
  logic latch_strobe, motor_on, spin_found, seek_ok, ready;
  bit toggle = 0, finished = 0;
  int cyc = 0, checks = 0, fails = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (toggle) latch_data <= latch_data + 8'd1;

  spindle_spinup #(
    .UNIT_TICKS(U), .SETTLE_UNITS(SET_UNITS), .NUM_CMP(NCMP),
    .CNT_PRELOAD(16'(65536 - PRE_UNITS))
  ) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .drive_sel(drive_sel),
    .stop(stop), .latch_data(latch_data), .us_tick(us_tick),
    .seek_done(seek_done), .latch_strobe(latch_strobe), .motor_on(motor_on),
    .spin_found(spin_found), .seek_ok(seek_ok), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: samples 2 ns after each rising edge, compares with queued items.
  initial begin
    int strobes = 0, m = 0, d = 0, er = 0;
    bit have = 0, pm = 0, ps = 0, pr = 0;
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (latch_strobe && !motor_on) strobes++;
      if (seek_done) d = cyc;
      if (motor_on && !pm && q.size() > 0) begin
        e = q.pop_front(); have = 1; m = cyc;
        chk(spin_found == e.spun, "R2/R3 spin_found", spin_found, e.spun);
        chk(strobes == e.strobes, "R1 strobe count", strobes, e.strobes);
      end
      if (have && seek_ok && !ps)
        chk((cyc - m) == (e.spun ? 0 : SET_UNITS * U), e.spun ? "R5 seek delay" : "R4 settle delay",
            cyc - m, e.spun ? 0 : SET_UNITS * U);
      if (have && ready && !pr) begin
        er = e.spun ? d : ((d > m + PRE_UNITS * U + 1) ? d : m + PRE_UNITS * U + 1);
        chk(cyc == er, e.spun ? "R8 ready timing" : "R6/R7 ready timing", cyc, er);
      end
      if (!motor_on && pm) begin strobes = 0; have = 0; end
      pm = motor_on; ps = seek_ok; pr = ready;
    end
  end

  task automatic run_op(input bit drv, input bit act, input int slen, input bit spun, input bit abort_it);
    exp_t e;
    int g = 0;
    if (!abort_it) begin
      e.spun = spun; e.strobes = act ? 2 : NCMP + 1;
      q.push_back(e);
    end
    toggle = act;
    @(negedge clk); drive_sel = drv; op_start = 1;
    @(negedge clk); op_start = 0;
    while (!seek_ok && g < 2000) begin @(negedge clk); g++; end
    if (abort_it) begin
      stop = 1; seek_done = 1;
      @(negedge clk); stop = 0; seek_done = 0;
      chk(!motor_on && !ready && !seek_ok, "R9 stop beats seek_done", motor_on, 0);
      repeat (5) @(negedge clk);
      chk(!ready && !motor_on, "R9 stays idle", ready, 0);
    end else begin
      repeat (slen) @(negedge clk);
      seek_done = 1;
      @(negedge clk); seek_done = 0;
      g = 0;
      while (!ready && g < 2000) begin @(negedge clk); g++; end
      op_start = 1;
      repeat (3) @(negedge clk);
      op_start = 0;
      chk(ready && motor_on, "R8 ready holds, start ignored", ready, 1);
      stop = 1;
      @(negedge clk); stop = 0;
      chk(!motor_on && !ready, "R9 stop motor off", motor_on, 0);
    end
    toggle = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!motor_on && !seek_ok && !ready && !spin_found && !latch_strobe,
        "R10 reset outputs", motor_on | seek_ok | ready, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!motor_on && !latch_strobe, "R10 idle after reset", motor_on, 0);
    run_op(1'b0, 1'b0, 5,   1'b0, 1'b0);  // R4 R6: still drive, short seek
    run_op(1'b0, 1'b1, 5,   1'b1, 1'b0);  // R5 R8: same drive, activity
    run_op(1'b1, 1'b1, 200, 1'b0, 1'b0);  // R2 R7: drive changed, long seek
    run_op(1'b1, 1'b1, 5,   1'b1, 1'b0);  // R2: drive repeated, activity
    run_op(1'b1, 1'b0, 130, 1'b0, 1'b0);  // R7: seek ends near expiry
    run_op(1'b0, 1'b0, 0,   1'b0, 1'b1);  // R9: stop with seek_done
    chk(q.size() == 0, "R3 all operations observed", q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end
endmodule